// File: doc/BRIEF.md
# Multi-Mode Iterative Integer Divider

This block divides a dividend by a 16-bit divisor one quotient bit per advancing clock. One datapath serves five operation kinds: signed and unsigned division of a 32-bit dividend, signed and unsigned division of a 16-bit dividend, and a signed fractional division of two Q15 values. A start pulse captures the mode, dividend and divisor. The controller then advances only in cycles where the step-enable input is high. An outside sequencer can therefore hold the operation at any step, and the partially built remainder and quotient wait in the block's own registers until stepping resumes.

Every operation takes exactly 18 advancing steps after the start cycle, whatever the mode, so a run without pauses delivers its result 19 cycles after start. The first step forms magnitudes and signs and checks for overflow. Sixteen steps form the quotient bits. The last step restores signs, checks the quotient range, saturates fractional results and registers the outputs. A single flag reports a zero divisor or a quotient that does not fit in 16 bits.

Top module: `iter_divider`

## Requirements
- R1: After synchronous reset, busy, done, ovf, quotient and remainder are all zero.
- R2: The mode field selects the operation: 0 = signed 32/16, 1 = unsigned 32/16, 2 = signed 16/16, 3 = unsigned 16/16, 4 = signed Q15 fractional. In the unsigned modes, quotient = floor(N/D) and remainder = N mod D.
- R3: In the signed modes, the quotient is truncated toward zero and a nonzero remainder has the sign of the dividend.
- R4: The 16/16 modes and the fractional mode use only dividend[15:0]. The signed modes sign-extend it and the unsigned mode zero-extends it. Bits [31:16] have no effect on the result.
- R5: The fractional mode divides dividend[15:0] times 2^15 by the signed divisor. When the true quotient lies outside [-32768, 32767] and the divisor is nonzero, quotient is 0x7FFF for a positive result and 0x8000 for a negative one, and ovf is set.
- R6: ovf is 1 when the divisor is zero, or when the exact quotient does not fit the 16-bit range of the mode (0..65535 unsigned, -32768..32767 signed). Otherwise ovf is 0. When ovf is 1, quotient and remainder carry no checked meaning, except as R5 states.
- R7: A start captured while idle makes busy go high. With step-enable held high, done rises and busy falls exactly 18 clock edges after the start edge, which is 19 cycles from issue to result.
- R8: In a cycle with step-enable low, the operation does not advance. The result is the same as without pauses, and it arrives after exactly 18 enabled steps.
- R9: A start pulse while busy is ignored. The running operation completes with the operands it captured.
- R10: After completion, done, ovf, quotient and remainder hold until the next accepted start, regardless of the other inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Captures mode, dividend and divisor when idle |
| step_en | input | 1 | Advances the operation one step when high |
| mode | input | 3 | Operation select (see R2) |
| dividend | input | 32 | Dividend; the 16-bit modes use bits [15:0] |
| divisor | input | 16 | Divisor |
| quotient | output | 16 | Result quotient |
| remainder | output | 16 | Result remainder |
| done | output | 1 | Result valid, held until next start |
| busy | output | 1 | Operation in progress |
| ovf | output | 1 | Zero divisor or quotient out of range |

## Verification
The assertions assume that start and step_en are known values after reset. They also assume that mode, dividend and divisor matter only in the cycle where an idle block sees start, so the checker's step counter treats every enabled cycle while busy as one step. The stimulus keeps to this: it presents operands together with the start pulse, and then changes them freely during the run and after done. It can pause a run with step_en low, and it can raise start in mid-run on purpose to check that the block ignores it.

// File: rtl/div_pkg.sv
package div_pkg;

    parameter int DIV_W = 16;
    localparam int DIVD_W = 2 * DIV_W;
    localparam int STEP_TOTAL = DIV_W + 2;
    localparam int CNT_W = $clog2(STEP_TOTAL);

    typedef enum logic [2:0] {
        MODE_S32  = 3'd0,
        MODE_U32  = 3'd1,
        MODE_S16  = 3'd2,
        MODE_U16  = 3'd3,
        MODE_FRAC = 3'd4
    } div_mode_e;

    // Working state carried between steps.
    typedef struct packed {
        logic [DIV_W-1:0] hi;      // partial remainder
        logic [DIV_W-1:0] lo;      // dividend bits out, quotient bits in
        logic [DIV_W-1:0] dmag;    // divisor magnitude
        logic             neg_n;   // dividend negative
        logic             neg_d;   // divisor negative
        logic             pre_ovf; // zero divisor or upper half too large
    } work_t;

    function automatic logic mode_is_signed(div_mode_e m);
        return (m == MODE_S32) || (m == MODE_S16) || (m == MODE_FRAC);
    endfunction

    // Brings the raw dividend to full width according to the mode.
    function automatic logic [DIVD_W-1:0] widen_dividend(div_mode_e m,
                                                         logic [DIVD_W-1:0] raw);
        logic [DIVD_W-1:0] w;
        case (m)
            MODE_S32, MODE_U32: w = raw;
            MODE_S16:  w = {{DIV_W{raw[DIV_W-1]}}, raw[DIV_W-1:0]};
            MODE_FRAC: w = {raw[DIV_W-1], raw[DIV_W-1:0], {(DIV_W-1){1'b0}}};
            default:   w = {{DIV_W{1'b0}}, raw[DIV_W-1:0]};
        endcase
        return w;
    endfunction

endpackage

// File: rtl/div_prep.sv
module div_prep
    import div_pkg::*;
(
    input  div_mode_e         mode_i,
    input  logic [DIVD_W-1:0] raw_n_i,
    input  logic [DIV_W-1:0]  raw_d_i,
    output work_t             work_o
);
    logic [DIVD_W-1:0] n_full;
    logic [DIVD_W-1:0] n_mag;
    logic [DIV_W-1:0]  d_mag;
    logic              sgn, n_neg, d_neg;

    always_comb begin
        n_full = widen_dividend(mode_i, raw_n_i);
        sgn    = mode_is_signed(mode_i);
        n_neg  = sgn & n_full[DIVD_W-1];
        d_neg  = sgn & raw_d_i[DIV_W-1];
        n_mag  = n_neg ? (~n_full + 1'b1) : n_full;
        d_mag  = d_neg ? (~raw_d_i + 1'b1) : raw_d_i;

        work_o.hi      = n_mag[DIVD_W-1:DIV_W];
        work_o.lo      = n_mag[DIV_W-1:0];
        work_o.dmag    = d_mag;
        work_o.neg_n   = n_neg;
        work_o.neg_d   = d_neg;
        work_o.pre_ovf = (d_mag == '0) || (n_mag[DIVD_W-1:DIV_W] >= d_mag);
    end
endmodule

// File: rtl/div_step.sv
module div_step
    import div_pkg::*;
(
    input  logic [DIV_W-1:0] hi_i,
    input  logic [DIV_W-1:0] lo_i,
    input  logic [DIV_W-1:0] dmag_i,
    output logic [DIV_W-1:0] hi_o,
    output logic [DIV_W-1:0] lo_o
);
    logic [DIV_W:0] trial;
    logic           take;

    always_comb begin
        trial = {hi_i, lo_i[DIV_W-1]};
        take  = (trial >= {1'b0, dmag_i});
        hi_o  = take ? DIV_W'(trial - {1'b0, dmag_i}) : trial[DIV_W-1:0];
        lo_o  = {lo_i[DIV_W-2:0], take};
    end
endmodule

// File: rtl/div_finish.sv
module div_finish
    import div_pkg::*;
(
    input  div_mode_e        mode_i,
    input  work_t            work_i,
    output logic [DIV_W-1:0] quot_o,
    output logic [DIV_W-1:0] rem_o,
    output logic             ovf_o
);
    localparam logic [DIV_W-1:0] NEG_LIMIT = {1'b1, {(DIV_W-1){1'b0}}};
    localparam logic [DIV_W-1:0] POS_LIMIT = ~NEG_LIMIT;

    logic neg_q, range_bad;

    always_comb begin
        neg_q = work_i.neg_n ^ work_i.neg_d;
        if (mode_is_signed(mode_i))
            range_bad = neg_q ? (work_i.lo > NEG_LIMIT) : (work_i.lo >= NEG_LIMIT);
        else
            range_bad = 1'b0;
        ovf_o  = work_i.pre_ovf | range_bad;
        quot_o = neg_q ? (~work_i.lo + 1'b1) : work_i.lo;
        rem_o  = work_i.neg_n ? (~work_i.hi + 1'b1) : work_i.hi;
        if ((mode_i == MODE_FRAC) && ovf_o && (work_i.dmag != '0))
            quot_o = neg_q ? NEG_LIMIT : POS_LIMIT;
    end
endmodule

// File: rtl/iter_divider.sv
module iter_divider
    import div_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              step_en,
    input  logic [2:0]        mode,
    input  logic [DIVD_W-1:0] dividend,
    input  logic [DIV_W-1:0]  divisor,
    output logic [DIV_W-1:0]  quotient,
    output logic [DIV_W-1:0]  remainder,
    output logic              done,
    output logic              busy,
    output logic              ovf
);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(STEP_TOTAL - 1);
    localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(DIV_W);

    div_mode_e         mode_q;
    logic [DIVD_W-1:0] raw_n_q;
    logic [DIV_W-1:0]  raw_d_q;
    work_t             work_q;
    work_t             prep_w;
    logic [CNT_W-1:0]  step_cnt;
    logic [DIV_W-1:0]  nxt_hi, nxt_lo, fin_q, fin_r;
    logic              fin_ovf;

    div_prep u_prep (
        .mode_i  (mode_q),
        .raw_n_i (raw_n_q),
        .raw_d_i (raw_d_q),
        .work_o  (prep_w)
    );

    div_step u_step (
        .hi_i   (work_q.hi),
        .lo_i   (work_q.lo),
        .dmag_i (work_q.dmag),
        .hi_o   (nxt_hi),
        .lo_o   (nxt_lo)
    );

    div_finish u_finish (
        .mode_i (mode_q),
        .work_i (work_q),
        .quot_o (fin_q),
        .rem_o  (fin_r),
        .ovf_o  (fin_ovf)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= MODE_S32;
            raw_n_q   <= '0;
            raw_d_q   <= '0;
            work_q    <= '0;
            step_cnt  <= '0;
            busy      <= 1'b0;
            done      <= 1'b0;
            ovf       <= 1'b0;
            quotient  <= '0;
            remainder <= '0;
        end else if (start && !busy) begin
            mode_q   <= div_mode_e'(mode);
            raw_n_q  <= dividend;
            raw_d_q  <= divisor;
            step_cnt <= '0;
            busy     <= 1'b1;
            done     <= 1'b0;
            ovf      <= 1'b0;
        end else if (busy && step_en) begin
            step_cnt <= step_cnt + 1'b1;
            if (step_cnt == '0) begin
                work_q <= prep_w;
            end else if (step_cnt <= LAST_BIT) begin
                work_q.hi <= nxt_hi;
                work_q.lo <= nxt_lo;
            end else if (step_cnt == LAST_STEP) begin
                quotient  <= fin_q;
                remainder <= fin_r;
                ovf       <= fin_ovf;
                done      <= 1'b1;
                busy      <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/div_checker.sv
module div_checker
    import div_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             step_en,
    input logic             busy,
    input logic             done,
    input logic             ovf,
    input logic [DIV_W-1:0] quotient,
    input logic [DIV_W-1:0] remainder,
    input logic [CNT_W-1:0] cnt
);
    logic [7:0] seen;

    always_ff @(posedge clk) begin
        if (rst)                 seen <= '0;
        else if (start && !busy) seen <= '0;
        else if (busy && step_en) seen <= seen + 1'b1;
    end

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (!busy && !done && !ovf)); // R1

    AST_STEP_COUNT: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (seen == 8'(STEP_TOTAL))); // R7

    AST_DONE_BUSY_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(done && busy)); // R7

    AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy && !step_en) |=> (busy && $stable(cnt))); // R8

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy && start && step_en && (cnt < CNT_W'(STEP_TOTAL - 1)))
        |=> (busy && (cnt == $past(cnt) + 1'b1))); // R9

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> (done && $stable(quotient) && $stable(remainder) && $stable(ovf))); // R10
endmodule

bind iter_divider div_checker u_div_checker (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .step_en   (step_en),
    .busy      (busy),
    .done      (done),
    .ovf       (ovf),
    .quotient  (quotient),
    .remainder (remainder),
    .cnt       (step_cnt)
);

// File: tb/test_iter_divider.sv
`timescale 1ns/1ps
module test_iter_divider;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        step_en = 1'b0;
    logic [2:0]  mode = 3'd0;
    logic [31:0] dividend = '0;
    logic [15:0] divisor = '0;
    logic [15:0] quotient, remainder;
    logic        done, busy, ovf;

    int checks = 0;
    int failures = 0;
    logic [31:0] lcg = 32'h1234_5678;

    always #2.5 clk = ~clk;

    iter_divider i_iter_divider (
        .clk(clk), .rst(rst), .start(start), .step_en(step_en),
        .mode(mode), .dividend(dividend), .divisor(divisor),
        .quotient(quotient), .remainder(remainder),
        .done(done), .busy(busy), .ovf(ovf)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rnd();
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        return lcg;
    endfunction

    // Arithmetic model from the requirements (R2..R6).
    task automatic model(input logic [2:0] m, input logic [31:0] a, input logic [15:0] b,
                         output logic [15:0] eq, output logic [15:0] er, output logic eo);
        longint n, d, q, r;
        bit sgn;
        sgn = (m != 3'd1) && (m != 3'd3);
        case (m)
            3'd0: n = $signed(a);
            3'd1: n = a;
            3'd2: n = $signed(a[15:0]);
            3'd3: n = a[15:0];
            default: n = $signed(a[15:0]) * 32768;
        endcase
        if (sgn) d = $signed(b);
        else     d = b;
        if (d == 0) begin
            eq = '0; er = '0; eo = 1'b1;
        end else begin
            q = n / d;
            r = n % d;
            eo = sgn ? ((q < -32768) || (q > 32767)) : (q > 65535);
            eq = q[15:0];
            er = r[15:0];
            if (m == 3'd4 && eo) eq = (q < 0) ? 16'h8000 : 16'h7FFF;
        end
    endtask

    task automatic run_op(input logic [2:0] m, input logic [31:0] a, input logic [15:0] b,
                          input bit pause, input bit restart);
        logic [15:0] eq, er, hq, hr;
        logic eo;
        int highs, j;
        string tag;
        model(m, a, b, eq, er, eo);
        @(negedge clk);
        mode = m; dividend = a; divisor = b; start = 1'b1; step_en = 1'b1;
        highs = 0; j = 0;
        forever begin
            @(negedge clk);
            if (done) break;
            if (j > 200) break;
            if (restart && j == 5) begin
                start = 1'b1; mode = ~m; dividend = ~a; divisor = b ^ 16'h0101;
            end else begin
                start = 1'b0;
            end
            step_en = pause ? ((j % 3) != 1) : 1'b1;
            if (step_en) highs++;
            j++;
        end
        start = 1'b0;
        // R7 / R8: done after exactly 18 enabled steps
        chk(pause ? "R8 enabled steps to done" : "R7 steps to done", highs, 18);
        if (eo) begin
            chk("R6 overflow flag", ovf, 1);
            if (m == 3'd4 && b != 16'h0) chk("R5 saturated quotient", quotient, eq);
        end else begin
            case (m)
                3'd1, 3'd3: tag = "R2/R4 unsigned";
                3'd4:       tag = "R5 fractional";
                default:    tag = "R3/R4 signed";
            endcase
            if (restart) tag = {tag, " R9 restart ignored"};
            chk({tag, " ovf"}, ovf, 0);
            chk({tag, " quotient"}, quotient, eq);
            chk({tag, " remainder"}, remainder, er);
        end
        // R10: results hold while other inputs move
        hq = quotient; hr = remainder;
        dividend = ~a; divisor = ~b; mode = 3'd1; step_en = 1'b1;
        @(negedge clk);
        chk("R10 done held", done, 1);
        chk("R10 quotient held", quotient, hq);
        chk("R10 remainder held", remainder, hr);
    endtask

    initial begin
        #(5.0 * 190000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] nl [10];
        logic [15:0] dl [8];
        nl = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h0000_7FFF, 32'h0000_8000,
               32'h8000_0000, 32'h7FFF_FFFF, 32'h0001_2345, 32'h0000_3039, 32'hFFFF_CFC7};
        dl = '{16'h0001, 16'hFFFF, 16'h0002, 16'h7FFF, 16'h8000, 16'h0000, 16'h0003, 16'hFFF9};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 ovf", ovf, 0);
        chk("R1 quotient", quotient, 0);
        chk("R1 remainder", remainder, 0);

        // Corner sweep over all modes
        for (int m = 0; m < 5; m++)
            for (int i = 0; i < 10; i++)
                for (int k = 0; k < 8; k++)
                    run_op(3'(m), nl[i], dl[k], ((i + k) % 4) == 0, (k % 7) == 3);

        // Pseudo-random sweep; upper dividend bits are garbage in the 16-bit modes (R4)
        for (int t = 0; t < 1200; t++) begin
            logic [31:0] a, sel;
            logic [15:0] b;
            sel = rnd();
            a = rnd();
            if (sel[0]) a = $signed(a) >>> sel[8:4];
            b = rnd() >> 16;
            if (sel[1]) b = $signed(b) >>> sel[12:9];
            run_op(3'(sel[31:16] % 5), a, b, sel[2] & sel[3], sel[13] & sel[14]);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule